// File: doc/BRIEF.md
# Line-Refill Read Sequencer

This block runs read cycles on a shared, time-multiplexed address/data bus for a processor's caches. A read request arrives with its address and two tags: whether it comes from a cache miss, and whether that miss is on the instruction side or the data side. Instruction misses always refill a whole four-word line. Data misses refill a whole line only if line refill for data was chosen while reset was held. Every other read fetches a single word.

A read has three bus phases. First comes a one-cycle address phase, in which the block drives the address and the byte strobes and pulses the address latch enable. Next comes a one-cycle turnaround, in which nobody drives the bus. Last comes a data phase, in which the memory drives the bus. Memory hands over each word by pulsing a capture strobe, which may come after any number of idle cycles, and it signals completion with an acknowledge. Each strobe writes the bus word into the next slot of a small read buffer and advances the word counter shown on the low-address pins.

Once the read has ended, the buffered words are sent to the cache side at one word per cycle. Two diagnostic pins carry the miss type during the address phase and the low bits of the miss address for the rest of the read. A bus error during the data phase aborts the read and raises a one-cycle exception request.

Top module: `burst_read_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ale`, `ad_oe`, `rd_str`, `data_en`, `burst`, `busy`, `bus_err` and `line_valid` are all low.
- R2: A request accepted while idle produces the address phase in the next cycle. In that cycle `ale`, `ad_oe` and `rd_str` are high, `ad_out` equals {address bits 31:4, 4'b1111}, and `diag` equals {miss, instr}.
- R3: `burst` is high throughout a read exactly when the read is a miss and is either an instruction read or a data read with line refill chosen. That choice is the value of `cfg_dquad` on the last clock edge with `rst` high. Changes to `cfg_dquad` after reset have no effect.
- R4: The address phase is followed by one turnaround cycle with `ad_oe` and `data_en` both low. `data_en` is then high for the whole data phase. It is low during the address phase, while idle and while delivering words.
- R5: In a line refill, `word_addr` starts at 0 and advances by one on each accepted strobe only. In a single read, `word_addr` holds address bits 3:2 of the request.
- R6: Each `rd_cen` seen high on a clock edge in the data phase writes `ad_in` into the next buffer slot, up to four words for a refill and one for a single read. Further strobes are ignored.
- R7: The data phase ends at the first edge where acknowledge has been seen (in that cycle or earlier) and all required words are held. An acknowledge that comes early does not cut the read short.
- R8: In the cycle after the data phase ends, delivery begins with `rd_str` low. Words leave at one per cycle with `line_valid` high and `line_idx` equal to the word position (0 to 3 for a refill, address bits 3:2 for a single read). `line_last` marks the final word, and the block is idle in the cycle after it.
- R9: In the turnaround and data phases, `diag` equals address bits 3:2 of the request.
- R10: `berr` high in the data phase ends the read at that edge, even if `rd_cen` is high in the same cycle. In the next cycle `bus_err` is high for one cycle, the block is idle and no word is delivered.
- R11: `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dquad | input | 1 | Line refill for data misses, sampled during reset |
| req_valid | input | 1 | Read request from the cache side |
| req_addr | input | 32 | Requested byte address |
| req_miss | input | 1 | Request is caused by a cache miss |
| req_instr | input | 1 | Request is from the instruction side |
| ad_in | input | 32 | Bus value driven by memory |
| ad_out | output | 32 | Bus value driven by this block |
| ad_oe | output | 1 | Block drives the bus |
| ale | output | 1 | Address latch enable |
| rd_str | output | 1 | Read cycle in progress on the bus |
| data_en | output | 1 | Memory may drive the bus |
| burst | output | 1 | Current read is a four-word refill |
| word_addr | output | 2 | Low word address / refill counter |
| diag | output | 2 | Miss type, then miss address bits 3:2 |
| rd_cen | input | 1 | Capture strobe for the read buffer |
| ack | input | 1 | Memory acknowledge |
| berr | input | 1 | Bus error |
| busy | output | 1 | Read in progress or delivering |
| bus_err | output | 1 | Bus-error exception request pulse |
| line_valid | output | 1 | Delivered word valid |
| line_data | output | 32 | Delivered word |
| line_idx | output | 2 | Position of the delivered word in the line |
| line_last | output | 1 | Final delivered word |

## Verification
The acknowledge can land on the same edge as the final capture strobe. It can also come earlier, on a cycle with no strobe, or one cycle later, after an extra strobe that has to be dropped. Vectors cover each of these three orderings, and for each the bench checks that the data phase lasts exactly until both conditions hold and that the delivered line matches the words given on the bus. In a separate test the bus error and a capture strobe arrive in the same cycle. The bench then expects the abort to win, with an exception pulse, no delivery, and an idle block one cycle later.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_TURN  = 3'd2,
    ST_DATA  = 3'd3,
    ST_DRAIN = 3'd4
  } brc_state_e;
endpackage

// File: rtl/brc_cfg.sv
module brc_cfg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_in,
  output logic cfg_q
);
  // captured on every edge while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/brc_rdbuf.sv
module brc_rdbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  localparam int IW        = $clog2(LINE_WORDS),
  localparam int CW        = $clog2(LINE_WORDS + 1),
  localparam int BEW       = DW / 8,
  localparam int BO        = $clog2(BEW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          quad_cfg,
  input  logic          req_valid,
  input  logic [DW-1:0] req_addr,
  input  logic          req_miss,
  input  logic          req_instr,
  input  logic          rd_cen,
  input  logic          ack,
  input  logic          berr,
  output logic [DW-1:0] addr_word,
  output logic          ale,
  output logic          ad_oe,
  output logic          rd_str,
  output logic          data_en,
  output logic          burst,
  output logic [IW-1:0] word_addr,
  output logic [1:0]    diag,
  output logic          busy,
  output logic          bus_err,
  output logic          buf_we,
  output logic [IW-1:0] buf_widx,
  output logic [IW-1:0] buf_ridx,
  output logic          line_valid,
  output logic [IW-1:0] line_idx,
  output logic          line_last
);
  brc_state_e    state;
  logic [DW-1:0] addr_q;
  logic          miss_q, instr_q, burst_q, ack_seen, err_q;
  logic [IW-1:0] cnt, didx;
  logic [CW-1:0] cap;

  logic [CW-1:0] need, cap_nx;
  logic          take, fin;
  logic [IW-1:0] low_word;

  assign low_word = addr_q[BO+IW-1:BO];
  assign need     = burst_q ? CW'(LINE_WORDS) : CW'(1);
  assign take     = (state == ST_DATA) && rd_cen && !berr && (cap < need);
  assign cap_nx   = cap + CW'(take);
  assign fin      = (state == ST_DATA) && !berr && (ack || ack_seen) && (cap_nx == need);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      miss_q   <= 1'b0;
      instr_q  <= 1'b0;
      burst_q  <= 1'b0;
      ack_seen <= 1'b0;
      err_q    <= 1'b0;
      cnt      <= '0;
      cap      <= '0;
      didx     <= '0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          miss_q   <= req_miss;
          instr_q  <= req_instr;
          burst_q  <= req_miss && (req_instr || quad_cfg);
          ack_seen <= 1'b0;
          cnt      <= '0;
          cap      <= '0;
          didx     <= '0;
          state    <= ST_ADDR;
        end
        ST_ADDR: state <= ST_TURN;
        ST_TURN: state <= ST_DATA;
        ST_DATA: begin
          if (berr) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end else begin
            if (take) cnt <= cnt + IW'(1);
            cap      <= cap_nx;
            ack_seen <= ack_seen | ack;
            if (fin) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (line_last) state <= ST_IDLE;
          else           didx  <= didx + IW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ale        = (state == ST_ADDR);
  assign ad_oe      = (state == ST_ADDR);
  assign rd_str     = (state == ST_ADDR) || (state == ST_TURN) || (state == ST_DATA);
  assign data_en    = (state == ST_DATA);
  assign burst      = burst_q && rd_str;
  assign word_addr  = rd_str ? (burst_q ? cnt : low_word) : '0;
  assign diag       = (state == ST_ADDR) ? {miss_q, instr_q} :
                      ((state == ST_TURN) || (state == ST_DATA)) ? addr_q[3:2] : 2'b00;
  assign busy       = (state != ST_IDLE);
  assign bus_err    = err_q;
  assign addr_word  = {addr_q[DW-1:BEW], {BEW{1'b1}}};
  assign buf_we     = take;
  assign buf_widx   = burst_q ? cnt : '0;
  assign buf_ridx   = didx;
  assign line_valid = (state == ST_DRAIN);
  assign line_idx   = burst_q ? didx : low_word;
  assign line_last  = (state == ST_DRAIN) && (CW'(didx) == need - CW'(1));

  // R3: a data-side refill in burst form needs the reset-time choice
  p_dquad_r3: assert property (@(posedge clk) disable iff (rst)
    (ale && burst && !diag[0]) |-> (quad_cfg && diag[1]));

  // R4: memory may drive only while this block has let go of the bus
  p_den_excl_r4: assert property (@(posedge clk) disable iff (rst)
    data_en |-> (!ad_oe && !ale));

  p_turn_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_en) |-> $past(rd_str && !ad_oe));

  // R5: the word counter only moves on an accepted strobe
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (data_en && !rd_cen) |=> $stable(cnt));

  // R7: delivery only starts with every required word held
  p_fin_full_r7: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(data_en)) |-> (cap == need));

  // R8: delivery never overlaps a bus read
  p_drain_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (!rd_str && !data_en));

  // R10: a bus error aborts without delivery
  p_berr_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (data_en && berr) |=> (bus_err && !busy && !line_valid));
endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl #(
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  localparam int IW        = $clog2(LINE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dquad,
  input  logic          req_valid,
  input  logic [DW-1:0] req_addr,
  input  logic          req_miss,
  input  logic          req_instr,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_str,
  output logic          data_en,
  output logic          burst,
  output logic [IW-1:0] word_addr,
  output logic [1:0]    diag,
  input  logic          rd_cen,
  input  logic          ack,
  input  logic          berr,
  output logic          busy,
  output logic          bus_err,
  output logic          line_valid,
  output logic [DW-1:0] line_data,
  output logic [IW-1:0] line_idx,
  output logic          line_last
);
  logic          quad_q;
  logic [DW-1:0] addr_word;
  logic          buf_we;
  logic [IW-1:0] buf_widx, buf_ridx;

  brc_cfg i_cfg (
    .clk    (clk),
    .rst    (rst),
    .cfg_in (cfg_dquad),
    .cfg_q  (quad_q)
  );

  brc_seq #(.DW(DW), .LINE_WORDS(LINE_WORDS)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .quad_cfg   (quad_q),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_miss   (req_miss),
    .req_instr  (req_instr),
    .rd_cen     (rd_cen),
    .ack        (ack),
    .berr       (berr),
    .addr_word  (addr_word),
    .ale        (ale),
    .ad_oe      (ad_oe),
    .rd_str     (rd_str),
    .data_en    (data_en),
    .burst      (burst),
    .word_addr  (word_addr),
    .diag       (diag),
    .busy       (busy),
    .bus_err    (bus_err),
    .buf_we     (buf_we),
    .buf_widx   (buf_widx),
    .buf_ridx   (buf_ridx),
    .line_valid (line_valid),
    .line_idx   (line_idx),
    .line_last  (line_last)
  );

  brc_rdbuf #(.DW(DW), .DEPTH(LINE_WORDS)) i_rdbuf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (ad_in),
    .rd_idx  (buf_ridx),
    .rd_data (line_data)
  );

  assign ad_out = ad_oe ? addr_word : '0;
endmodule

// File: tb/test_burst_read_ctrl.sv
module test_burst_read_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dquad = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_miss = 1'b0;
  logic        req_instr = 1'b0;
  logic [31:0] ad_in = '0;
  logic        rd_cen = 1'b0;
  logic        ack = 1'b0;
  logic        berr = 1'b0;
  logic [31:0] ad_out, line_data;
  logic        ad_oe, ale, rd_str, data_en, burst, busy, bus_err;
  logic        line_valid, line_last;
  logic [1:0]  word_addr, diag, line_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  burst_read_ctrl i_burst_read_ctrl (
    .clk(clk), .rst(rst), .cfg_dquad(cfg_dquad), .req_valid(req_valid),
    .req_addr(req_addr), .req_miss(req_miss), .req_instr(req_instr),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_str(rd_str),
    .data_en(data_en), .burst(burst), .word_addr(word_addr), .diag(diag),
    .rd_cen(rd_cen), .ack(ack), .berr(berr), .busy(busy), .bus_err(bus_err),
    .line_valid(line_valid), .line_data(line_data), .line_idx(line_idx),
    .line_last(line_last)
  );

  // addr, miss, instr, gap, ack mode (0: with last strobe, 1: early, 2: late after extra strobe)
  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {32'h0000_1238, 1'b1, 1'b1, 2'd0, 2'd0},
    {32'h0040_0034, 1'b1, 1'b1, 2'd2, 2'd1},
    {32'h1000_000C, 1'b1, 1'b0, 2'd1, 2'd0},
    {32'hBFC0_0108, 1'b0, 1'b1, 2'd0, 2'd2},
    {32'h0000_8F70, 1'b1, 1'b1, 2'd3, 2'd2},
    {32'hA000_0004, 1'b0, 1'b0, 2'd1, 2'd1}
  };

  function automatic logic [31:0] wordval(logic [31:0] a, int k);
    return (a ^ 32'h1357_9BDF) + 32'h0101_0101 * k;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(logic [31:0] a, logic m, logic ins, int gap, int ackm,
                         logic quad, bit hold_req);
    logic       bst;
    int         n;
    logic [1:0] wa;
    bst = m && (ins || quad);
    n   = bst ? 4 : 1;
    wa  = a[3:2];
    req_valid = 1'b1; req_addr = a; req_miss = m; req_instr = ins;
    @(negedge clk);
    if (hold_req) begin
      req_addr = 32'hFFFF_0000;
    end else begin
      req_valid = 1'b0;
    end
    chk("R2 ale", ale, 1);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 ad_out", ad_out, {a[31:4], 4'hF});
    chk("R2 rd_str", rd_str, 1);
    chk("R2 diag", diag, {m, ins});
    chk("R3 burst", burst, bst);
    chk("R4 den addr phase", data_en, 0);
    chk("R5 word_addr start", word_addr, bst ? 2'd0 : wa);
    @(negedge clk);
    chk("R4 turn ad_oe", ad_oe, 0);
    chk("R4 turn data_en", data_en, 0);
    chk("R9 diag turn", diag, wa);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        rd_cen = 1'b0;
        ack = (ackm == 1 && k == 0 && g == 0);
        chk("R4 data_en gap", data_en, 1);
        @(negedge clk);
        ack = 1'b0;
      end
      rd_cen = 1'b1;
      ad_in = wordval(a, k);
      ack = (ackm == 0 && k == n - 1);
      chk("R5 word_addr", word_addr, bst ? k[1:0] : wa);
      chk("R7 still reading", data_en, 1);
      chk("R9 diag data", diag, wa);
      chk("R3 burst held", burst, bst);
      @(negedge clk);
      rd_cen = 1'b0;
      ack = 1'b0;
    end
    if (ackm == 2) begin
      rd_cen = 1'b1;
      ad_in = 32'hDEAD_BEEF;
      chk("R7 waits for ack", data_en, 1);
      @(negedge clk);
      rd_cen = 1'b0;
      ack = 1'b1;
      chk("R7 waits for ack 2", data_en, 1);
      @(negedge clk);
      ack = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      if (hold_req && k == n - 1) req_valid = 1'b0;
      chk("R8 line_valid", line_valid, 1);
      chk("R6 line_data", line_data, wordval(a, k));
      chk("R8 line_idx", line_idx, bst ? k[1:0] : wa);
      chk("R8 line_last", line_last, k == n - 1);
      chk("R8 rd_str low", rd_str, 0);
      chk("R4 den drain", data_en, 0);
      @(negedge clk);
    end
    chk("R8 idle after", busy, 0);
    chk("R8 no more words", line_valid, 0);
  endtask

  task automatic do_reset(logic q);
    rst = 1'b1;
    cfg_dquad = q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    @(negedge clk);
    chk("R1 ale in reset", ale, 0);
    chk("R1 busy in reset", busy, 0);
    do_reset(1'b0);
    chk("R1 ale", ale, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 rd_str", rd_str, 0);
    chk("R1 data_en", data_en, 0);
    chk("R1 burst", burst, 0);
    chk("R1 busy", busy, 0);
    chk("R1 bus_err", bus_err, 0);
    chk("R1 line_valid", line_valid, 0);

    for (int v = 0; v < NV; v++) begin
      do_read(VEC[v][37:6], VEC[v][5], VEC[v][4], int'(VEC[v][3:2]),
              int'(VEC[v][1:0]), 1'b0, 1'b0);
      @(negedge clk);
    end

    // R11: request held high during a read is not taken afterwards
    do_read(32'h0000_2004, 1'b0, 1'b0, 1, 0, 1'b0, 1'b1);
    chk("R11 no new read", ale, 0);
    @(negedge clk);
    chk("R11 still idle", busy, 0);

    // R10: bus error together with a strobe
    req_valid = 1'b1; req_addr = 32'h0000_3330; req_miss = 1'b1; req_instr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd_cen = 1'b1; berr = 1'b1; ad_in = 32'h1111_2222;
    chk("R10 in data phase", data_en, 1);
    @(negedge clk);
    rd_cen = 1'b0; berr = 1'b0;
    chk("R10 bus_err pulse", bus_err, 1);
    chk("R10 idle", busy, 0);
    chk("R10 rd_str low", rd_str, 0);
    chk("R10 no delivery", line_valid, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", bus_err, 0);
    chk("R10 still no delivery", line_valid, 0);

    // R3: data-side refill chosen in reset, later change ignored
    do_reset(1'b1);
    cfg_dquad = 1'b0;
    do_read(32'h2000_0048, 1'b1, 1'b0, 1, 0, 1'b1, 1'b0);
    @(negedge clk);
    // R3: uncached data read stays single even with refill chosen
    do_read(32'h2000_004C, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule